// File: doc/BRIEF.md
# SPI byte master with status-bit retry

This block is an SPI master for a peripheral that answers every byte transfer with a one-bit status. A write can be refused because the peripheral's receive buffer is full. A read can return a byte that was already delivered. Each transfer is a fixed frame of 13 serial-clock periods. The frame carries a start bit, a direction bit, a register-select bit, eight data bits, a status slot and a turnaround slot.

The master samples the status in the one clock period where it is valid. After a refusal or a stale byte, the master repeats the identical frame on its own. It stops when the write is accepted or when fresh read data arrives. If the retry budget runs out first, it raises a timeout pulse and goes back to idle. The user side has a single command channel with a valid/ready handshake, a read-data output with a one-cycle valid flag, and the timeout pulse. The serial clock is divided from the system clock.

Top module: `spi_retry_master`

## Requirements
- R1: After reset, sclk, cs and sdi are 0, req_ready is 1, and rd_valid and timeout are 0.
- R2: A frame is 13 sclk periods. Each period is 2*DIV system clocks, low half first. cs is high (active) for the first 12 periods and low in the 13th. cs only falls together with a falling sclk.
- R3: sdi carries the following, by period: period 0 a 1 (start); period 1 the direction (1 = read); period 2 the register select (0 = data, 1 = status register); periods 3 to 10 the byte, MSB first; periods 11 and 12 a 0. sdi never changes while sclk stays high.
- R4: sdo is sampled when sclk rises. The value presented in period k is captured at the rising edge of period k+1. Read data is presented in periods 3 to 10, MSB first. The status is presented in period 11 and captured at the rising edge of period 12 only.
- R5: For a write, status 0 (accept) ends the command. Status 1 (reject) makes the master resend the same frame with the same byte, one idle system clock after the previous frame.
- R6: For a read, status 0 (fresh data) makes rd_data valid with a one-cycle rd_valid pulse, one clock after the frame ends. Status 1 (stale data) drops the byte without any pulse and repeats the frame after one idle clock.
- R7: After RETRY_MAX consecutive frames with status 1, timeout pulses for one cycle, with no rd_valid, and the master returns to idle.
- R8: req_ready is 1 only while the master is idle, with cs and sclk low. A command is taken on req_valid && req_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Master idle, command can be taken |
| req_read | input | 1 | 1 = read, 0 = write |
| req_reg | input | 1 | Register select sent in period 2 |
| req_wdata | input | 8 | Byte sent in periods 3 to 10 |
| rd_valid | output | 1 | One-cycle pulse, rd_data holds fresh read byte |
| rd_data | output | 8 | Read byte |
| timeout | output | 1 | One-cycle pulse after RETRY_MAX failed frames |
| sclk | output | 1 | Serial clock |
| cs | output | 1 | Chip select, active high |
| sdi | output | 1 | Serial data to peripheral |
| sdo | input | 1 | Serial data and status from peripheral |

## Verification
Take the command to be accepted at clock edge E, and let F = 26*DIV. Frame n (counting from 0) then starts at E + n*(F+1). Its cs, sclk and sdi values are fixed functions of the clock offset inside that frame, with sclk rising DIV clocks into each period. When n frames are needed, both the rd_valid or timeout pulse and the return of req_ready fall exactly n*(F+1) clocks after E. The reference model in the bench computes all of these from the offset since acceptance and the scripted number of peripheral refusals. It compares every output on each falling system-clock edge, one clock past the outcome as well. The peripheral model drives the status in period 11 only and replaces it with its inverse at the next rising sclk, so a capture one period late is visible.

// File: rtl/spi_retry_pkg.sv
package spi_retry_pkg;

  localparam int BYTE_W = 8;

  // frame slot indices that the serial behaviour depends on
  localparam logic [3:0] SLOT_RX_FIRST  = 4'd4;   // first rise capturing read data
  localparam logic [3:0] SLOT_RX_LAST   = 4'd11;  // last rise capturing read data
  localparam logic [3:0] SLOT_CS_LAST   = 4'd11;  // last period with cs high
  localparam logic [3:0] SLOT_END       = 4'd12;  // turnaround, status captured here

  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_BUSY = 2'd1
  } ctl_state_t;

  typedef struct packed {
    logic              rd;
    logic              reg_sel;
    logic [BYTE_W-1:0] payload;
  } frame_cmd_t;

  // value driven on sdi during a given frame period
  function automatic logic slot_sdi(input frame_cmd_t c, input logic [3:0] s);
    logic [BYTE_W-1:0] sh;
    sh = c.payload << (s - 4'd3);
    case (s)
      4'd0:  return 1'b1;
      4'd1:  return c.rd;
      4'd2:  return c.reg_sel;
      4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10: return sh[BYTE_W-1];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic          phase_hi;
  logic          wrap;

  assign wrap      = run && (cnt == CW'(DIV - 1));
  assign rise_tick = wrap && !phase_hi;
  assign fall_tick = wrap && phase_hi;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt      <= '0;
      phase_hi <= 1'b0;
    end else if (wrap) begin
      cnt      <= '0;
      phase_hi <= ~phase_hi;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_retry_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  frame_cmd_t        cmd_in,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              sdo,
  output logic              busy,
  output logic              sclk,
  output logic              cs,
  output logic              sdi,
  output logic              done,
  output logic              status,
  output logic [BYTE_W-1:0] rx_byte
);
  frame_cmd_t        cmd;
  logic [3:0]        slot;
  logic [3:0]        slot_nx;
  logic [BYTE_W-1:0] shreg;

  assign slot_nx = slot + 4'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      cs      <= 1'b0;
      sdi     <= 1'b0;
      done    <= 1'b0;
      status  <= 1'b0;
      rx_byte <= '0;
      shreg   <= '0;
      slot    <= '0;
      cmd     <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        cmd  <= cmd_in;
        slot <= '0;
        sclk <= 1'b0;
        cs   <= 1'b1;
        sdi  <= slot_sdi(cmd_in, 4'd0);
      end else if (busy) begin
        if (rise_tick) begin
          sclk <= 1'b1;
          if (slot >= SLOT_RX_FIRST && slot <= SLOT_RX_LAST)
            shreg <= {shreg[BYTE_W-2:0], sdo};
          if (slot == SLOT_END)
            status <= sdo;
        end else if (fall_tick) begin
          sclk <= 1'b0;
          if (slot == SLOT_END) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            cs      <= 1'b0;
            sdi     <= 1'b0;
            rx_byte <= shreg;
          end else begin
            slot <= slot_nx;
            cs   <= (slot_nx <= SLOT_CS_LAST);
            sdi  <= slot_sdi(cmd, slot_nx);
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_retry_master.sv
module spi_retry_master
  import spi_retry_pkg::*;
#(
  parameter int DIV       = 2,
  parameter int RETRY_MAX = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic              req_reg,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              timeout,
  output logic              sclk,
  output logic              cs,
  output logic              sdi,
  input  logic              sdo
);
  localparam int RW = $clog2(RETRY_MAX + 1);

  ctl_state_t        state;
  frame_cmd_t        held;
  frame_cmd_t        cmd_in;
  logic [RW-1:0]     fails;
  logic              accept, retry, last_try, start;
  logic              busy, done, status, rise_tick, fall_tick;
  logic [BYTE_W-1:0] rx_byte;

  assign req_ready = (state == CTL_IDLE);
  assign accept    = req_valid && req_ready;
  assign last_try  = (fails == RW'(RETRY_MAX - 1));
  assign retry     = (state == CTL_BUSY) && done && status && !last_try;
  assign start     = accept || retry;
  assign cmd_in    = accept ? frame_cmd_t'{rd: req_read, reg_sel: req_reg, payload: req_wdata}
                            : held;

  spi_clk_div #(.DIV(DIV)) i_div (
    .clk       (clk),
    .rst       (rst),
    .run       (busy),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  spi_frame_engine i_eng (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cmd_in    (cmd_in),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .sdo       (sdo),
    .busy      (busy),
    .sclk      (sclk),
    .cs        (cs),
    .sdi       (sdi),
    .done      (done),
    .status    (status),
    .rx_byte   (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CTL_IDLE;
      held     <= '0;
      fails    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      timeout  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      timeout  <= 1'b0;
      case (state)
        CTL_IDLE: begin
          if (accept) begin
            held  <= cmd_in;
            fails <= '0;
            state <= CTL_BUSY;
          end
        end
        CTL_BUSY: begin
          if (done) begin
            if (!status) begin
              if (held.rd) begin
                rd_valid <= 1'b1;
                rd_data  <= rx_byte;
              end
              state <= CTL_IDLE;
            end else if (last_try) begin
              timeout <= 1'b1;
              state   <= CTL_IDLE;
            end else begin
              fails <= fails + RW'(1);
            end
          end
        end
        default: state <= CTL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_retry_master_chk.sv
module spi_retry_master_chk (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic rd_valid,
  input logic timeout,
  input logic sclk,
  input logic cs,
  input logic sdi
);
  // R2
  cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs) |-> $fell(sclk));

  // R3
  sdi_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdi));

  // R3
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs) |-> sdi);

  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!cs && !sclk));

  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R7
  timeout_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout);

  // R7
  timeout_excl_chk: assert property (@(posedge clk) disable iff (rst)
    timeout |-> !rd_valid);
endmodule

bind spi_retry_master spi_retry_master_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .timeout   (timeout),
  .sclk      (sclk),
  .cs        (cs),
  .sdi       (sdi)
);

// File: tb/test_spi_retry_master.sv
module test_spi_retry_master;
  localparam int DIV       = 2;
  localparam int RETRY_MAX = 4;
  localparam int F         = 26 * DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_read = 1'b0;
  logic       req_reg = 1'b0;
  logic [7:0] req_wdata = 8'h00;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       timeout;
  logic       sclk, cs, sdi;
  logic       sdo = 1'b0;

  int checks = 0;
  int fails  = 0;

  // peripheral script, written only by the stimulus tasks
  int         cfg_fail  = 0;
  logic [7:0] cfg_fresh = 8'h00;

  always #4 clk = ~clk;

  spi_retry_master #(.DIV(DIV), .RETRY_MAX(RETRY_MAX)) i_spi_retry_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_reg(req_reg), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .timeout(timeout),
    .sclk(sclk), .cs(cs), .sdi(sdi), .sdo(sdo)
  );

  // peripheral model: acts after each rising sclk, seen on the falling clk edge
  logic sclk_prev = 1'b0;
  int   rcnt = 0;
  int   frame_no = 0;
  logic frame_dir = 1'b0;
  logic frame_ok = 1'b0;
  logic last_status = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      sdo = 1'b0; rcnt = 0; frame_no = 0; sclk_prev = 1'b0;
    end else begin
      if (req_valid) frame_no = 0;
      if (sclk && !sclk_prev) begin
        if (cs) begin
          if (rcnt == 0) frame_ok = (frame_no >= cfg_fail);
          if (rcnt == 1) frame_dir = sdi;
          if (rcnt >= 3 && rcnt <= 10)
            sdo = frame_dir ? (frame_ok ? cfg_fresh[10-rcnt] : ~cfg_fresh[10-rcnt]) : 1'b1;
          if (rcnt == 11) begin
            last_status = !frame_ok;
            sdo = last_status;
            frame_no = frame_no + 1;
          end
          rcnt = rcnt + 1;
        end else begin
          sdo = ~last_status;   // status window closed
        end
      end
      if (!cs) rcnt = 0;
      sclk_prev = sclk;
    end
  end

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic exp_sdi(input int slot, input logic rd, input logic rg,
                                   input logic [7:0] wd);
    if (slot == 0) return 1'b1;
    if (slot == 1) return rd;
    if (slot == 2) return rg;
    if (slot >= 3 && slot <= 10) return wd[10-slot];
    return 1'b0;
  endfunction

  task automatic run_txn(input logic rd, input logic rg, input logic [7:0] wd,
                         input int nfail, input logic [7:0] fresh);
    int   n;
    logic ok;
    string rq;
    ok = (nfail < RETRY_MAX);
    n  = ok ? nfail + 1 : RETRY_MAX;
    rq = ok ? (rd ? "R6" : "R5") : "R7";
    cfg_fail  = nfail;
    cfg_fresh = fresh;
    @(negedge clk);
    check(req_ready == 1'b1, "R8", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_read = rd; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~wd;
    for (int c = 0; c <= n*(F+1) + 1; c++) begin
      int   t, slot;
      logic act, e_cs, e_sclk, e_sdi;
      t    = c % (F+1);
      slot = t / (2*DIV);
      act  = (c < n*(F+1));
      e_cs   = act && (t < 24*DIV);
      e_sclk = act && (t < F) && (((t / DIV) % 2) == 1);
      e_sdi  = act && (t < F) && exp_sdi(slot, rd, rg, wd);
      check(cs == e_cs, "R2", "cs", int'(cs), int'(e_cs));
      check(sclk == e_sclk, "R2", "sclk", int'(sclk), int'(e_sclk));
      check(sdi == e_sdi, "R3", "sdi", int'(sdi), int'(e_sdi));
      check(req_ready == !act, rq, "ready", int'(req_ready), int'(!act));
      check(rd_valid == (c == n*(F+1) && rd && ok), rq, "rd_valid",
            int'(rd_valid), int'(c == n*(F+1) && rd && ok));
      check(timeout == (c == n*(F+1) && !ok), "R7", "timeout",
            int'(timeout), int'(c == n*(F+1) && !ok));
      if (c == n*(F+1) && rd && ok)
        check(rd_data == fresh, "R4", "rd_data", int'(rd_data), int'(fresh));
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(sclk == 0 && cs == 0 && sdi == 0, "R1", "serial idle", {sclk, cs, sdi}, 0);
    check(req_ready == 1'b1, "R1", "ready", int'(req_ready), 1);
    check(rd_valid == 0 && timeout == 0, "R1", "pulses", {rd_valid, timeout}, 0);
    run_txn(1'b0, 1'b0, 8'hA5, 0, 8'h00);  // R5 accepted first time
    run_txn(1'b0, 1'b0, 8'h3C, 2, 8'h00);  // R5 two rejects then accept
    run_txn(1'b1, 1'b0, 8'h00, 0, 8'h81);  // R6 fresh read
    run_txn(1'b1, 1'b0, 8'hFF, 3, 8'h5E);  // R6 three stale reads dropped
    run_txn(1'b1, 1'b1, 8'h0F, 1, 8'hC3);  // R4 status register read
    run_txn(1'b0, 1'b1, 8'h96, 4, 8'h00);  // R7 write budget exhausted
    run_txn(1'b1, 1'b0, 8'h12, 6, 8'h77);  // R7 read budget exhausted
    run_txn(1'b0, 1'b0, 8'h01, 3, 8'h00);  // R5 accepted on last allowed try
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule